// File: doc/BRIEF.md
# Shift, Rotate and Negate Unit

This unit is the bit-manipulation slice of an 8-bit processor datapath. In one operation it shifts left, shifts right, rotates left through the carry, or forms the two's complement of a byte. The shifts can also work on the 16-bit double accumulator, which is formed by placing accumulator A above accumulator B.

Each request is a single cycle with `inValid` high. It carries an operation code, a width select, the operand and the current carry flag. On the next clock edge the unit registers the result and the four arithmetic flags: negative, zero, overflow and carry. It also registers a set of write-enables that tell the condition-code register which flags to take. Operand fetch, addressing and instruction decode are handled outside the unit.

Top module: `shift_neg_unit`

## Requirements
- R1: After reset `outValid`, `result`, all four flags and `flagWe` are 0 until the first request completes.
- R2: A request sampled with `inValid` high appears on the outputs on the next clock edge, with `outValid` high for exactly that one cycle. In a cycle with `inValid` low, `outValid` falls and `result` and the flags keep their last values.
- R3: `opCode` 2'b00 is logical shift left. A 0 enters bit 0, and C takes the bit shifted out of the top: bit 7 in byte mode, or bit 15 when `wideSel` is 1.
- R4: `opCode` 2'b01 is logical shift right. A 0 enters the top bit (bit 7, or bit 15 when `wideSel` is 1), and C takes the old bit 0.
- R5: `opCode` 2'b10 is rotate left through carry. `carryIn` enters bit 0 and C takes old bit 7. This operation always works on the byte, and `wideSel` has no effect on it.
- R6: `opCode` 2'b11 is negate. The result is 0 minus the operand byte. C is 1 when the result is nonzero, and V is 1 only when the operand byte was 8'h80. `wideSel` has no effect on this operation.
- R7: N is the top bit of the result: bit 7 in byte mode, bit 15 in wide mode. For the 16-bit shift right, N is always 0.
- R8: Z is 1 exactly when the whole result is zero. In byte mode, `operand[15:8]` is ignored and `result[15:8]` is 0.
- R9: After any shift or rotate, V equals N XOR C, with both flags taken after the operation.
- R10: `flagWe` is ordered {N, Z, V, C} from bit 3 down to bit 0. It is 4'b1111 in the cycle `outValid` is high and 4'b0000 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opCode | input | 2 | 00 shift left, 01 shift right, 10 rotate left, 11 negate |
| wideSel | input | 1 | 1 selects the 16-bit form of the shifts |
| operand | input | 16 | Operand; byte forms use bits 7:0 |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Result valid for one cycle |
| result | output | 16 | Operation result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |
| flagWe | output | 4 | Flag write-enables {N,Z,V,C} |

## Verification
Two situations are the hardest to reach from the ports.

The first is the single operand 8'h80 under negate, where the result equals the input and both V and C must be set. The second is the wide shift right, where N is forced to 0 no matter what bit 15 of the operand held.

The stimulus reaches both cases by sweeping every byte operand with both carry-in values through all four operations. It then runs the two wide shifts across all 256 values of the upper byte, paired with several lower-byte patterns. Finally, it applies `wideSel` and a nonzero upper byte to rotate and negate, so that any leak of the upper byte into those results would show at the ports.

// File: rtl/shift_neg_pkg.sv
package shift_neg_pkg;
  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_ROL = 2'b10,
    OP_NEG = 2'b11
  } opKind_e;

  typedef struct packed {
    logic capture;
    logic doShl;
    logic doShr;
    logic doRol;
    logic doNeg;
    logic useWide;
  } strobe_t;
endpackage

// File: rtl/shift_neg_ctrl.sv
module shift_neg_ctrl
  import shift_neg_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opCode,
  input  logic       wideSel,
  output strobe_t    strobe
);
  opKind_e kind;

  always_comb begin
    kind           = opKind_e'(opCode);
    strobe         = '0;
    strobe.capture = inValid;
    unique case (kind)
      OP_SHL:  strobe.doShl = 1'b1;
      OP_SHR:  strobe.doShr = 1'b1;
      OP_ROL:  strobe.doRol = 1'b1;
      default: strobe.doNeg = 1'b1;
    endcase
    // only the two shifts have a double-width form
    strobe.useWide = wideSel && (kind == OP_SHL || kind == OP_SHR);
  end
endmodule

// File: rtl/shift_neg_dp.sv
module shift_neg_dp
  import shift_neg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] operand,
  input  logic              carryIn,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic [3:0]        flagWe
);
  localparam logic [BYTE_W-1:0] MIN_NEG = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [BYTE_W-1:0] ZERO_BYTE = '0;

  logic [BYTE_W-1:0] opByte;
  logic [BYTE_W-1:0] negByte;
  logic [WORD_W-1:0] nextRes;
  logic              nextN, nextZ, nextV, nextC;

  assign opByte  = operand[BYTE_W-1:0];
  assign negByte = ZERO_BYTE - opByte;

  always_comb begin
    nextRes = '0;
    nextC   = 1'b0;
    if (strobe.doShl) begin
      if (strobe.useWide) begin
        nextRes = {operand[WORD_W-2:0], 1'b0};
        nextC   = operand[WORD_W-1];
      end else begin
        nextRes[BYTE_W-1:0] = {opByte[BYTE_W-2:0], 1'b0};
        nextC               = opByte[BYTE_W-1];
      end
    end else if (strobe.doShr) begin
      if (strobe.useWide) nextRes = {1'b0, operand[WORD_W-1:1]};
      else nextRes[BYTE_W-1:0] = {1'b0, opByte[BYTE_W-1:1]};
      nextC = operand[0];
    end else if (strobe.doRol) begin
      nextRes[BYTE_W-1:0] = {opByte[BYTE_W-2:0], carryIn};
      nextC               = opByte[BYTE_W-1];
    end else begin
      nextRes[BYTE_W-1:0] = negByte;
      nextC               = (negByte != ZERO_BYTE);
    end

    if (strobe.useWide) nextN = strobe.doShr ? 1'b0 : nextRes[WORD_W-1];
    else nextN = nextRes[BYTE_W-1];
    nextZ = (nextRes == '0);
    nextV = strobe.doNeg ? (opByte == MIN_NEG) : (nextN ^ nextC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
      flagWe   <= 4'b0000;
    end else begin
      outValid <= strobe.capture;
      flagWe   <= {4{strobe.capture}};
      if (strobe.capture) begin
        result <= nextRes;
        flagN  <= nextN;
        flagZ  <= nextZ;
        flagV  <= nextV;
        flagC  <= nextC;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> outValid) else $error("one cycle"); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (!outValid && $stable(result))) else $error("hold"); // R2
  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.doNeg) |=> (flagV == (flagN ^ flagC))) else $error("shift V"); // R9
  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.doNeg) |=> (flagC == (result != '0))) else $error("neg C"); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagZ == (result == '0))) else $error("Z"); // R8
  AST_WIDE_SHR_N: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.doShr && strobe.useWide) |=> !flagN) else $error("wide N"); // R7
  AST_WE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagWe == 4'b1111)) else $error("we"); // R10
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.useWide) |=> (result[WORD_W-1:BYTE_W] == '0)) else $error("upper"); // R8
endmodule

// File: rtl/shift_neg_unit.sv
module shift_neg_unit
  import shift_neg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opCode,
  input  logic              wideSel,
  input  logic [WORD_W-1:0] operand,
  input  logic              carryIn,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic [3:0]        flagWe
);
  strobe_t strobe;

  shift_neg_ctrl u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .wideSel (wideSel),
    .strobe  (strobe)
  );

  shift_neg_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operand),
    .carryIn  (carryIn),
    .outValid (outValid),
    .result   (result),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC),
    .flagWe   (flagWe)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (!outValid && flagWe == 4'b0000)) else $error("reset"); // R1
endmodule

// File: tb/shift_neg_unit_tb.sv
module shift_neg_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic        wideSel = 1'b0;
  logic [15:0] operand = '0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [15:0] result;
  logic        flagN, flagZ, flagV, flagC;
  logic [3:0]  flagWe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shift_neg_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .wideSel(wideSel), .operand(operand), .carryIn(carryIn),
    .outValid(outValid), .result(result), .flagN(flagN), .flagZ(flagZ),
    .flagV(flagV), .flagC(flagC), .flagWe(flagWe)
  );

  // expected packed as {result[15:0], N, Z, V, C, outValid, we[3:0]}
  function automatic logic [24:0] expect_of(input int op, input bit wide,
                                            input int val, input bit cin);
    int r; int c; int n; int v; int b; int width;
    b = val & 255;
    width = 8;
    case (op)
      0: if (wide) begin r = (val * 2) % 65536; c = val / 32768; width = 16; end
         else begin r = (b * 2) % 256; c = b / 128; end
      1: if (wide) begin r = val / 2; c = val % 2; width = 16; end
         else begin r = b / 2; c = b % 2; end
      2: begin r = ((b * 2) % 256) + cin; c = b / 128; end
      default: begin r = (256 - b) % 256; c = (r != 0); end
    endcase
    n = (width == 16) ? (r / 32768) % 2 : (r / 128) % 2;
    if (op == 3) v = (b == 128);
    else v = (n != c);
    expect_of = {r[15:0], n[0], (r == 0), v[0], c[0], 1'b1, 4'b1111};
  endfunction

  task automatic check(input string req, input logic [24:0] exp);
    logic [24:0] act;
    act = {result, flagN, flagZ, flagV, flagC, outValid, flagWe};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input int op, input bit wide,
                        input int val, input bit cin);
    @(negedge clk);
    inValid = 1'b1; opCode = op[1:0]; wideSel = wide;
    operand = val[15:0]; carryIn = cin;
    @(negedge clk);
    inValid = 1'b0;
    check(req, expect_of(op, wide, val, cin));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1", 25'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 25'd0);
  endtask

  task automatic test_hold();
    logic [24:0] e;
    run_op("R2", 3, 1'b0, 8'h80, 1'b0);
    e = expect_of(3, 1'b0, 8'h80, 1'b0);
    operand = 16'h1234; opCode = 2'b00;
    @(negedge clk);
    e[4:0] = 5'b00000;
    check("R2 hold R10", e);
  endtask

  task automatic test_byte_sweep();
    for (int op = 0; op < 4; op++)
      for (int cin = 0; cin < 2; cin++)
        for (int b = 0; b < 256; b++)
          // upper byte is noise that must be ignored (R8)
          run_op(op == 0 ? "R3 R8 R9" : op == 1 ? "R4 R8 R9" :
                 op == 2 ? "R5 R9" : "R6 R7", op, 1'b0, (b ^ 8'h5A) * 256 + b, cin[0]);
  endtask

  task automatic test_wide_shifts();
    int lows [4] = '{0, 1, 128, 255};
    for (int hi = 0; hi < 256; hi++)
      for (int k = 0; k < 4; k++) begin
        run_op("R3 R7 wide", 0, 1'b1, hi * 256 + lows[k], k[0]);
        run_op("R4 R7 wide", 1, 1'b1, hi * 256 + lows[k], k[0]);
      end
  endtask

  task automatic test_wide_ignored();
    for (int b = 0; b < 256; b += 17) begin
      run_op("R5 wide ignored", 2, 1'b1, 16'hA500 + b, 1'b1);
      run_op("R6 wide ignored", 3, 1'b1, 16'hFF00 + b, 1'b0);
    end
    run_op("R6 min neg", 3, 1'b1, 16'h7F80, 1'b0);
    run_op("R8 zero", 3, 1'b0, 16'hFF00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_hold();
    test_byte_sweep();
    test_wide_shifts();
    test_wide_ignored();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule